// File: doc/BRIEF.md
# SPI Slave with Busy/Ready Pacing

This block is a byte-wide SPI target that never starts a transfer on its own. The host selects it with an active-low select and toggles the serial clock. Command bytes come in on MOSI and reply bytes go out on MISO, both most significant bit first. An extra ready output paces the host. The host may start a byte only while ready is high. Each completed byte pulls ready low for a busy interval, and the length of that interval depends on the command. The block keeps the last command it received, so a resynchronisation command can answer with the complement of that command. A host that sends the resynchronisation byte repeatedly gets 0xF0 back once the stream is aligned.

All three host inputs pass through two-flop synchronisers, and clock edges are detected in the system clock domain. The system clock must therefore run several times faster than the serial clock. The flow control works as follows. The host waits while ready is low. Ready falls a few system cycles after the eighth rising edge. The reply to a byte is placed in the shift register no later than the cycle in which ready rises again. The host reads that reply during its next byte, which may be the null filler 0x00. The ready pin is modelled as a level plus a drive enable that is active while the line is held low, so the drive enable stands in for an open-drain output.

Top module: `spi_ready_slave`

## Requirements
- R1: The serial clock idles high. MOSI is sampled on rising edges and MISO changes only on falling edges, both MSB first.
- R2: After reset, ready stays low for POR_CYCLES system cycles and then rises. The drive enable is high exactly while ready is low.
- R3: Ready drops after every complete eight-bit byte and does not fall at any other time.
- R4: After an ordinary byte (any value other than 0x01 and 0x0E, the filler 0x00 included), ready stays low for SHORT_BUSY cycles. No low period is shorter than SHORT_BUSY.
- R5: After command 0x01 or 0x0E, ready stays low for LONG_BUSY cycles.
- R6: An ordinary non-zero command is answered with its own value, which the host shifts out during the following byte. Before any command has been received, the pending reply is 0x00.
- R7: Command 0x0F is answered with the bitwise complement of the previously stored command, and 0x0F then becomes the stored command. The stored command is 0x00 after reset, so repeated 0x0F bytes yield 0xF0.
- R8: The filler 0x00 is answered with 0x00 and leaves the stored command unchanged.
- R9: If select is released before the eighth bit, the partial byte is discarded. Ready does not fall, and the pending reply is offered again on the next selection.
- R10: The MISO drive enable is high only while select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from host, idles high |
| ss_n_i | input | 1 | Active-low select from host |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial reply data to host |
| miso_oe_o | output | 1 | MISO drive enable |
| rdy_o | output | 1 | Ready level, high when the host may send |
| rdy_oe_o | output | 1 | Drive enable that pulls the ready line low |

## Verification
The main function is tried with a run of resynchronisation bytes straight after reset. This run shows that the initial 0x00 reply, the complement of the reset value of the stored command, and the settled 0xF0 are three distinct steps. The run is then interleaved with ordinary commands, the filler and the two slow commands. This tells an echo apart from a complement, shows that the filler leaves the stored command alone, and separates the long busy time from the short one by measuring the ready-low length of each byte. An aborted half byte followed by a resynchronisation byte shows that a partial byte neither changes the stored command nor drops ready, and that the pending reply is offered again.

// File: rtl/spi_rdy_pkg.sv
package spi_rdy_pkg;
  localparam logic [7:0] CMD_NULL   = 8'h00;
  localparam logic [7:0] CMD_RESYNC = 8'h0F;
  localparam logic [7:0] CMD_SLOW_A = 8'h01;
  localparam logic [7:0] CMD_SLOW_B = 8'h0E;

  function automatic logic is_slow(input logic [7:0] cmd);
    return (cmd == CMD_SLOW_A) || (cmd == CMD_SLOW_B);
  endfunction

  function automatic logic [7:0] reply_for(input logic [7:0] cmd, input logic [7:0] last);
    if (cmd == CMD_NULL)   return 8'h00;
    if (cmd == CMD_RESYNC) return ~last;
    return cmd;
  endfunction

  function automatic logic [7:0] next_last(input logic [7:0] cmd, input logic [7:0] last);
    return (cmd == CMD_NULL) ? last : cmd;
  endfunction
endpackage

// File: rtl/spi_rdy_sync.sv
module spi_rdy_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_rdy_shift.sv
module spi_rdy_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck_s,
  input  logic            ss_act,
  input  logic            mosi_s,
  input  logic            load_en,
  input  logic [BITS-1:0] load_byte,
  output logic            miso,
  output logic            byte_done,
  output logic [BITS-1:0] rx_byte
);
  localparam int IW = $clog2(BITS);

  logic            sck_d;
  logic [IW-1:0]   bit_idx;
  logic [BITS-1:0] rx_sh, tx_sh, hold_q;
  logic            rise, fall;

  assign rise = ss_act & ~sck_d & sck_s;
  assign fall = ss_act & sck_d & ~sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d     <= 1'b1;
      bit_idx   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      hold_q    <= '0;
      miso      <= 1'b0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      sck_d     <= sck_s;
      byte_done <= 1'b0;
      if (!ss_act) begin
        bit_idx <= '0;
        rx_sh   <= '0;
      end else if (rise) begin
        rx_sh <= {rx_sh[BITS-2:0], mosi_s};
        if (bit_idx == IW'(BITS-1)) begin
          bit_idx   <= '0;
          byte_done <= 1'b1;
          rx_byte   <= {rx_sh[BITS-2:0], mosi_s};
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
      if (load_en) begin
        tx_sh  <= load_byte;
        hold_q <= load_byte;
      end else if (!ss_act) begin
        tx_sh <= hold_q;
      end else if (fall) begin
        miso  <= tx_sh[BITS-1];
        tx_sh <= {tx_sh[BITS-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_rdy_pace.sv
module spi_rdy_pace
  import spi_rdy_pkg::*;
#(
  parameter int POR_CYCLES = 100000,
  parameter int SHORT_BUSY = 4000,
  parameter int LONG_BUSY  = 2500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_done,
  input  logic [7:0] rx_byte,
  output logic       rdy,
  output logic       load_en,
  output logic [7:0] load_byte
);
  localparam int MAXC = (POR_CYCLES > LONG_BUSY) ?
                        ((POR_CYCLES > SHORT_BUSY) ? POR_CYCLES : SHORT_BUSY) :
                        ((LONG_BUSY > SHORT_BUSY) ? LONG_BUSY : SHORT_BUSY);
  localparam int CW = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [7:0]    last_q, pend_q;

  assign load_en   = !rdy && (cnt == '0) && !byte_done;
  assign load_byte = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy    <= 1'b0;
      cnt    <= CW'(POR_CYCLES - 1);
      last_q <= CMD_NULL;
      pend_q <= 8'h00;
    end else if (byte_done) begin
      rdy    <= 1'b0;
      cnt    <= is_slow(rx_byte) ? CW'(LONG_BUSY - 1) : CW'(SHORT_BUSY - 1);
      pend_q <= reply_for(rx_byte, last_q);
      last_q <= next_last(rx_byte, last_q);
    end else if (!rdy) begin
      if (cnt == '0) rdy <= 1'b1;
      else           cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/spi_ready_slave.sv
module spi_ready_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int POR_CYCLES  = 100000,
  parameter int SHORT_BUSY  = 4000,
  parameter int LONG_BUSY   = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic ss_n_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic miso_oe_o,
  output logic rdy_o,
  output logic rdy_oe_o
);
  logic [2:0] sync_q;
  logic       sck_s, ss_n_s, mosi_s, ss_act;
  logic       byte_done, load_en;
  logic [7:0] rx_byte, load_byte;

  spi_rdy_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i({mosi_i, ss_n_i, sck_i}), .q_o(sync_q)
  );
  assign sck_s  = sync_q[0];
  assign ss_n_s = sync_q[1];
  assign mosi_s = sync_q[2];
  assign ss_act = ~ss_n_s;

  spi_rdy_shift #(.BITS(8)) shift_i (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .ss_act(ss_act), .mosi_s(mosi_s),
    .load_en(load_en), .load_byte(load_byte), .miso(miso_o),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  spi_rdy_pace #(.POR_CYCLES(POR_CYCLES), .SHORT_BUSY(SHORT_BUSY), .LONG_BUSY(LONG_BUSY)) pace_i (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
    .rdy(rdy_o), .load_en(load_en), .load_byte(load_byte)
  );

  assign miso_oe_o = ss_act;
  assign rdy_oe_o  = ~rdy_o;
endmodule

// File: rtl/spi_rdy_chk.sv
module spi_rdy_chk #(
  parameter int SHORT_BUSY = 4000
) (
  input logic clk,
  input logic rst_n,
  input logic rdy,
  input logic byte_done,
  input logic ss_act,
  input logic sck_s,
  input logic miso
);
  logic [31:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_run <= '0;
    else if (rdy)          low_run <= '0;
    else if (~&low_run)    low_run <= low_run + 1'b1;
  end

  a_r1_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(sck_s) |=> $stable(miso));
  a_r3_low_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !rdy);
  a_r3_no_spurious_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !byte_done) |=> rdy);
  a_r4_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> (low_run >= 32'(SHORT_BUSY)));
  a_r9_byte_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(ss_act));
endmodule

bind spi_ready_slave spi_rdy_chk #(.SHORT_BUSY(SHORT_BUSY)) chk_i (
  .clk(clk), .rst_n(rst_n), .rdy(rdy_o), .byte_done(byte_done),
  .ss_act(ss_act), .sck_s(sck_s), .miso(miso_o)
);

// File: tb/spi_ready_slave_tb_top.sv
module spi_ready_slave_tb_top;
  localparam int POR   = 300;
  localparam int SHORT = 60;
  localparam int LONG  = 400;
  localparam int HALF  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b1, ss_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, rdy, rdy_oe;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_byte;
  event got_ev;
  logic [7:0] m_pend = 8'h00, m_last = 8'h00;

  always #5 clk = ~clk;

  spi_ready_slave #(.POR_CYCLES(POR), .SHORT_BUSY(SHORT), .LONG_BUSY(LONG)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .rdy_o(rdy), .rdy_oe_o(rdy_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!rdy) @(negedge clk);
  endtask

  // measures ready-low length after the byte just clocked in
  task automatic measure_low(output int low);
    int guard = 0;
    low = 0;
    while (rdy && guard < 50) begin guard++; @(negedge clk); end
    while (!rdy) begin
      low++;
      if (low == 1) check(rdy_oe == 1'b1, "R2 drive enable while low", rdy_oe, 1);
      @(negedge clk);
    end
  endtask

  // driver: pushes the expected reply, clocks the byte, hands result to monitor
  task automatic xfer(input logic [7:0] cmd);
    logic [7:0] rxb;
    int low, exp_low;
    wait_ready();
    exp_q.push_back(m_pend);
    m_pend = (cmd == 8'h00) ? 8'h00 : (cmd == 8'h0F) ? ~m_last : cmd;
    if (cmd != 8'h00) m_last = cmd;
    exp_low = (cmd == 8'h01 || cmd == 8'h0E) ? LONG : SHORT;
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    check(miso_oe == 1'b1, "R10 miso enabled under select", miso_oe, 1);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; mosi = cmd[i];
      repeat (HALF) @(negedge clk);
      rxb[i] = miso;
      sck = 1'b1;
      if (i != 0) repeat (HALF) @(negedge clk);
    end
    got_byte = rxb;
    -> got_ev;
    measure_low(low);
    check(low >= exp_low - 1 && low <= exp_low + 1,
          (exp_low == LONG) ? "R5 long busy" : "R4 short busy", low, exp_low);
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
    check(miso_oe == 1'b0, "R10 miso released", miso_oe, 0);
  endtask

  // monitor: pops expected reply and compares (R6 R7 R8 R1)
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) check(1'b0, "R6 unexpected reply", got_byte, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(got_byte == e, "R6 R7 R8 reply byte", got_byte, e);
      end
    end
  end

  initial begin
    int por_low;
    repeat (3) @(negedge clk);
    check(rdy == 1'b0 && rdy_oe == 1'b1, "R2 reset state", {rdy, rdy_oe}, 2'b01);
    check(miso_oe == 1'b0, "R10 idle after reset", miso_oe, 0);
    rst_n = 1'b1;
    por_low = 0;
    @(negedge clk);
    while (!rdy) begin por_low++; @(negedge clk); end
    check(por_low >= POR - 2 && por_low <= POR + 1, "R2 power-up hold", por_low, POR);
    check(rdy_oe == 1'b0, "R2 drive released", rdy_oe, 0);

    xfer(8'h0F);   // reply 00
    xfer(8'h0F);   // reply FF
    xfer(8'h0F);   // reply F0
    xfer(8'h01);   // reply F0, long busy
    xfer(8'h35);   // reply 01
    xfer(8'h00);   // reply 35, filler
    xfer(8'h0F);   // reply 00 (filler reply), next ~35
    xfer(8'h0E);   // reply CA, long busy
    xfer(8'hA5);   // reply 0E

    // R9: aborted partial byte
    wait_ready();
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      sck = 1'b0; mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    ss_n = 1'b1;
    repeat (40) @(negedge clk);
    check(rdy == 1'b1, "R9 ready kept after abort", rdy, 1);

    xfer(8'h0F);   // reply A5 again, next 5A
    xfer(8'h00);   // reply 5A
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R6 all replies seen", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R3: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule